// File: doc/BRIEF.md
# SMBus DAC Code Register

This block is the serial front end of a 10-bit current-output DAC. It watches the two SMBus wires, oversampling them with a fast system clock. It answers one of four 7-bit slave addresses, chosen by a pair of strap inputs. Each accepted write frame carries a 3-bit mode field, a 1-bit flag and a 10-bit DAC code. The block acknowledges by pulling SDA low through an open-drain pull-down, which is shown here as the `sda_pull` output.

A valid frame is written to the held registers only after its last byte has been acknowledged. A frame that is cut short by STOP or by a new START leaves the old setting unchanged. At reset the straps also pick the starting code: midscale for one setting, zero for the other three. An active-low shutdown input drops the output enable and keeps the stored code, so the same code comes back when shutdown is released.

Top module: `smbdac_top`

## Requirements
- R1: The straps `strap[1:0]` set the 7-bit slave address: 0 gives 0x2D, 1 gives 0x2F, 2 gives 0x2E and 3 gives 0x2C. An address byte (address in bits 7:1, R/W in bit 0) that matches and has R/W=0 is acknowledged: `sda_pull` is high while SCL is high in the ninth clock.
- R2: If the address byte does not match, or R/W=1, that byte and every byte after it up to the next START get no acknowledge, and the held values do not change.
- R3: The first data byte carries the mode in bits 7:5, the flag in bit 4 and code bits 9:8 in bits 1:0. Bits 3:2 are ignored. The second data byte carries code bits 7:0. Both data bytes are acknowledged.
- R4: After reset the mode and flag are 0. The code is 0x200 for strap 3 and 0x000 for straps 0, 1 and 2.
- R5: The held values change only once the acknowledge of the second data byte is complete. A frame that ends early changes nothing.
- R6: `dac_en` equals `shdn_n` one clock later. Mode, flag and code stay as they are while `shdn_n` is low, and the same values are present after it returns high.
- R7: A START (SDA falls while SCL is high) restarts the frame at its address byte, even in the middle of a frame. A STOP (SDA rises while SCL is high) returns the block to idle with SDA released.
- R8: `sda_pull` is never high while SCL is high during one of the eight data bits of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| scl_in | input | 1 | SMBus clock line |
| sda_in | input | 1 | SMBus data line, as seen on the wire |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain acknowledge) |
| strap | input | 2 | Address and default-code select |
| shdn_n | input | 1 | Active-low shutdown |
| dac_code | output | 10 | Stored DAC code |
| dac_mode | output | 3 | Stored 3-bit mode field |
| dac_flag | output | 1 | Stored 1-bit flag |
| dac_en | output | 1 | DAC output enable |

## Verification
Both bus wires go through two synchroniser flops and an edge register before the state register. As a result, `sda_pull` rises about four system clocks after the SCL fall that ends the eighth bit, and the held values change about four clocks after the SCL fall that ends the final acknowledge. The bench keeps each SCL quarter period at six clocks. It reads the acknowledge and the stray-pull monitor in the middle of an SCL high phase, and it reads the held values only after the STOP has settled for twelve clocks. `dac_en` has a latency of one clock, and the bench reads it two clocks after changing `shdn_n`.

// File: rtl/smbdac_pkg.sv
package smbdac_pkg;
    localparam int CODE_W = 10;
    localparam int MODE_W = 3;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int HI_W   = CODE_W - BYTE_W;
    localparam int BITC_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              flag;
        logic [CODE_W-1:0] code;
    } dac_word_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_ACK,
        RX_SKIP
    } rx_state_t;

    function automatic logic [ADDR_W-1:0] strap_addr(input logic [1:0] s);
        case (s)
            2'd0:    return 7'h2D;
            2'd1:    return 7'h2F;
            2'd2:    return 7'h2E;
            default: return 7'h2C;
        endcase
    endfunction

    function automatic logic [CODE_W-1:0] strap_default(input logic [1:0] s);
        return (s == 2'd3) ? (CODE_W'(1) << (CODE_W - 1)) : '0;
    endfunction
endpackage

// File: rtl/smbdac_sync.sv
module smbdac_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] sh_q;
        logic              prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q   <= '1;
                prev_q <= 1'b1;
            end else begin
                sh_q   <= {sh_q[STAGES-2:0], din[g]};
                prev_q <= sh_q[STAGES-1];
            end
        end
        assign lvl[g]  = sh_q[STAGES-1];
        assign rise[g] = sh_q[STAGES-1] & ~prev_q;
        assign fall[g] = ~sh_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/smbdac_rx.sv
module smbdac_rx
    import smbdac_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_lvl,
    input  logic      scl_rise,
    input  logic      scl_fall,
    input  logic      sda_lvl,
    input  logic      sda_rise,
    input  logic      sda_fall,
    input  logic [1:0] strap,
    output logic      sda_pull,
    output logic      commit,
    output dac_word_t wdata
);
    rx_state_t         st_q;
    logic [BITC_W-1:0] bit_q;
    logic [1:0]        byte_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] hold_q;
    logic              commit_q;
    dac_word_t         word_q;
    logic              start;
    logic              stop;
    logic              full;

    assign start = scl_lvl & sda_fall;
    assign stop  = scl_lvl & sda_rise;
    assign full  = (bit_q == BITC_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= RX_IDLE;
            bit_q    <= '0;
            byte_q   <= '0;
            sh_q     <= '0;
            hold_q   <= '0;
            commit_q <= 1'b0;
            word_q   <= '0;
        end else begin
            commit_q <= 1'b0;
            if (start) begin
                st_q   <= RX_SHIFT;
                bit_q  <= '0;
                byte_q <= '0;
            end else if (stop) begin
                st_q <= RX_IDLE;
            end else begin
                case (st_q)
                    RX_SHIFT: begin
                        if (scl_rise && !full) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
                            bit_q <= bit_q + 1'b1;
                        end else if (scl_fall && full) begin
                            if (byte_q == 2'd0)
                                st_q <= (sh_q[BYTE_W-1:1] == strap_addr(strap) && !sh_q[0])
                                        ? RX_ACK : RX_SKIP;
                            else
                                st_q <= RX_ACK;
                            if (byte_q == 2'd1)
                                hold_q <= sh_q;
                        end
                    end
                    RX_ACK: begin
                        if (scl_fall) begin
                            bit_q <= '0;
                            if (byte_q == 2'd2) begin
                                st_q        <= RX_SKIP;
                                commit_q    <= 1'b1;
                                word_q.mode <= hold_q[BYTE_W-1 -: MODE_W];
                                word_q.flag <= hold_q[BYTE_W-1-MODE_W];
                                word_q.code <= {hold_q[HI_W-1:0], sh_q};
                            end else begin
                                byte_q <= byte_q + 1'b1;
                                st_q   <= RX_SHIFT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = (st_q == RX_ACK);
    assign commit   = commit_q;
    assign wdata    = word_q;

    // R5
    commit_once_chk: assert property (@(posedge clk) disable iff (rst)
        commit_q |=> !commit_q);
    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> !sda_pull);
    // R2
    skip_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_SKIP) |=> !commit_q);
endmodule

// File: rtl/smbdac_regs.sv
module smbdac_regs
    import smbdac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] strap,
    input  logic       shdn_n,
    input  logic       en_mode,
    input  logic       en_code,
    input  dac_word_t  wdata,
    output dac_word_t  held,
    output logic       dac_en
);
    dac_word_t word_q;
    logic      en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q.mode <= '0;
            word_q.flag <= 1'b0;
            word_q.code <= strap_default(strap);
            en_q        <= 1'b0;
        end else begin
            if (en_mode)
                word_q.mode <= wdata.mode;
            if (en_code) begin
                word_q.flag <= wdata.flag;
                word_q.code <= wdata.code;
            end
            en_q <= shdn_n;
        end
    end

    assign held   = word_q;
    assign dac_en = en_q;

    // R3
    code_load_chk: assert property (@(posedge clk) disable iff (rst)
        en_code |=> (held.code == $past(wdata.code)));
    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_code |=> $stable(held.code));
    // R6
    en_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (dac_en == $past(shdn_n)));
endmodule

// File: rtl/smbdac_top.sv
module smbdac_top
    import smbdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [1:0]        strap,
    input  logic              shdn_n,
    output logic [CODE_W-1:0] dac_code,
    output logic [MODE_W-1:0] dac_mode,
    output logic              dac_flag,
    output logic              dac_en
);
    logic [1:0] lvl, rise, fall;
    logic       commit;
    dac_word_t  wdata;
    dac_word_t  held;

    smbdac_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({sda_in, scl_in}),
        .lvl (lvl),
        .rise(rise),
        .fall(fall)
    );

    smbdac_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .scl_lvl (lvl[0]),
        .scl_rise(rise[0]),
        .scl_fall(fall[0]),
        .sda_lvl (lvl[1]),
        .sda_rise(rise[1]),
        .sda_fall(fall[1]),
        .strap   (strap),
        .sda_pull(sda_pull),
        .commit  (commit),
        .wdata   (wdata)
    );

    smbdac_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .strap  (strap),
        .shdn_n (shdn_n),
        .en_mode(commit),
        .en_code(commit),
        .wdata  (wdata),
        .held   (held),
        .dac_en (dac_en)
    );

    assign dac_code = held.code;
    assign dac_mode = held.mode;
    assign dac_flag = held.flag;
endmodule

// File: tb/sim_smbdac_top.sv
module sim_smbdac_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 6;
    localparam int H = 12;
    localparam int NV = 6;
    // {addr byte, data1, data2, ack expected, code, mode, flag}
    localparam logic [38:0] VEC [NV] = '{
        {8'h5A, 8'hE7, 8'h55, 1'b1, 10'h355, 3'd7, 1'b0},
        {8'h5A, 8'h12, 8'hA0, 1'b1, 10'h2A0, 3'd0, 1'b1},
        {8'h5B, 8'h00, 8'h00, 1'b0, 10'h2A0, 3'd0, 1'b1},
        {8'h5E, 8'hFF, 8'hFF, 1'b0, 10'h2A0, 3'd0, 1'b1},
        {8'h5A, 8'h0C, 8'h00, 1'b1, 10'h000, 3'd0, 1'b0},
        {8'h5A, 8'hFF, 8'hFF, 1'b1, 10'h3FF, 3'd7, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] strap = 2'd0;
    logic shdn_n = 1'b1;
    logic sda_pull;
    logic sda_line;
    logic [9:0] dac_code;
    logic [2:0] dac_mode;
    logic dac_flag, dac_en;
    int checks = 0;
    int fails = 0;
    int stray = 0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD / 2) clk = ~clk;

    smbdac_top u0 (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .strap(strap), .shdn_n(shdn_n),
        .dac_code(dac_code), .dac_mode(dac_mode), .dac_flag(dac_flag),
        .dac_en(dac_en)
    );

    function automatic logic [6:0] addr_of(input logic [1:0] s);
        case (s)
            2'd0:    return 7'h2D;
            2'd1:    return 7'h2F;
            2'd2:    return 7'h2E;
            default: return 7'h2C;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            if (sda_pull) stray++;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic frame(input logic [7:0] a, input logic [7:0] d1, input logic [7:0] d2,
                         output bit k0, output bit k1, output bit k2);
        bus_start();
        send_byte(a, k0);
        send_byte(d1, k1);
        send_byte(d2, k2);
        bus_stop();
    endtask

    initial begin
        bit k0, k1, k2;
        do_reset();
        // R4 reset state for strap 0
        chk(dac_code == 10'h000, "R4", dac_code, 10'h000);
        chk(dac_mode == 3'd0 && dac_flag == 1'b0, "R4", {dac_mode, dac_flag}, 0);
        chk(dac_en == 1'b1, "R6", dac_en, 1);

        // table walk: R1 R2 R3
        for (int v = 0; v < NV; v++) begin
            frame(VEC[v][38:31], VEC[v][30:23], VEC[v][22:15], k0, k1, k2);
            chk(k0 == VEC[v][14], "R1", k0, VEC[v][14]);
            chk((k1 & k2) == VEC[v][14] && (k1 | k2) == VEC[v][14], "R2", {k1, k2},
                {2{VEC[v][14]}});
            chk(dac_code == VEC[v][13:4], "R3", dac_code, VEC[v][13:4]);
            chk(dac_mode == VEC[v][3:1] && dac_flag == VEC[v][0], "R3",
                {dac_mode, dac_flag}, VEC[v][3:0]);
        end

        // R6 shutdown keeps code
        shdn_n = 1'b0; tick(2);
        chk(dac_en == 1'b0, "R6", dac_en, 0);
        chk(dac_code == 10'h3FF && dac_mode == 3'd7, "R6", dac_code, 10'h3FF);
        shdn_n = 1'b1; tick(2);
        chk(dac_en == 1'b1 && dac_code == 10'h3FF, "R6", {dac_en, dac_code}, 11'h7FF);

        // R5 aborted frame
        bus_start();
        send_byte(8'h5A, k0);
        send_byte(8'h80, k1);
        bus_stop();
        chk(dac_code == 10'h3FF && dac_mode == 3'd7, "R5", dac_code, 10'h3FF);

        // R7 repeated start mid frame
        bus_start();
        send_byte(8'h5A, k0);
        send_byte(8'h40, k1);
        bus_start();
        send_byte(8'h5A, k0);
        send_byte(8'h01, k1);
        send_byte(8'h23, k2);
        bus_stop();
        chk(k0 && k1 && k2, "R7", {k0, k1, k2}, 3'b111);
        chk(dac_code == 10'h123 && dac_mode == 3'd0 && !dac_flag, "R7", dac_code, 10'h123);
        chk(!sda_pull, "R7", sda_pull, 0);

        // R1 R4 R2 across straps
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            do_reset();
            chk(dac_code == ((s == 3) ? 10'h200 : 10'h000), "R4", dac_code,
                (s == 3) ? 10'h200 : 10'h000);
            frame({addr_of(2'(s)), 1'b0}, 8'h03, 8'h5A, k0, k1, k2);
            chk(k0 && k1 && k2, "R1", {k0, k1, k2}, 3'b111);
            chk(dac_code == 10'h35A, "R1", dac_code, 10'h35A);
            frame({addr_of(2'(s + 1)), 1'b0}, 8'hE0, 8'h11, k0, k1, k2);
            chk(!k0 && !k1 && !k2, "R2", {k0, k1, k2}, 0);
            chk(dac_code == 10'h35A && dac_mode == 3'd0, "R2", dac_code, 10'h35A);
        end

        // R8 no pull during data bits
        chk(stray == 0, "R8", stray, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule